// File: doc/BRIEF.md
# Narrow-to-wide bus lane mapper

This block sits between a 32-bit processor-side bus and a 64-bit memory data bus, which has a 4-bit side bus beside it that carries one extra bit per byte lane. The block takes one access at a time: a 32-bit write word, an address, a byte size and a read or write flag. It places the word onto the wide bus or the side bus according to the selected lane mode. It also produces the transfer count for the memory-interface controller. On a read it picks the 32-bit result out of the returned doubleword, or out of the side bits. Addresses at or above `MEM_LIMIT` belong to register space. For those the mode has no effect and the word passes through in the low half.

The mode and the repeat count live in a small control register that software loads through plain pins. The request side, the memory side and the read-response side each use a valid/ready handshake. The block accepts a new request only when it is idle. Once an output is valid it stays unchanged until ready is seen high at a clock edge. Read data returned from memory is qualified by `mem_rvalid` alone and is always accepted.

Top module: `lane_mapper`

## Requirements
- R1: After reset the mode is normal, `req_ready` is 1, and `mem_valid` and `rsp_valid` are 0.
- R2: In normal mode a memory write with address bit 2 = 0 drives the word on bits 63:32, and with bit 2 = 1 on bits 31:0. The other half is zero, `mem_count` equals `req_size` and `mem_side` is zero.
- R3: In upper mode a memory write always drives the word on bits 63:32 and the low half is zero. A memory read always returns bits 63:32.
- R4: In side mode a memory write drives `mem_side[i]` = word bit i for i = 0..3, with the 64-bit data zero and `mem_count` = `req_size`. A memory read returns `{28'b0, mem_rside}`.
- R5: In repeat mode a memory write drives the word on both halves, and `mem_count` is the programmed repeat count.
- R6: A memory read in repeat mode issues no memory request. It returns one response with `rsp_err` = 1 and data zero.
- R7: In normal mode a memory read returns bits 63:32 when address bit 2 = 0 and bits 31:0 when it is 1, with `rsp_err` = 0.
- R8: A register-space access ignores the mode. A write drives the word on bits 31:0 with the count equal to `req_size`, side zero and `mem_regspace` = 1. A read returns bits 31:0 without error, even in repeat mode.
- R9: When a control write sets several mode bits, repeat takes priority over side, and side over upper.
- R10: `mem_valid` and its payload stay stable until `mem_ready`, and `rsp_valid` and its payload stay stable until `rsp_ready`. `req_ready` is 1 only when no access is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register load strobe |
| cfg_upper | input | 1 | Request upper mode |
| cfg_side | input | 1 | Request side-bus mode |
| cfg_rep | input | 1 | Request repeat mode |
| cfg_rep_cnt | input | 7 | Repeat transfer count |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_size | input | 3 | Access size in bytes (1..4) |
| req_wdata | input | 32 | Write word |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory controller accepts request |
| mem_write | output | 1 | Memory request direction |
| mem_addr | output | 32 | Memory request address |
| mem_count | output | 7 | Transfer count for the memory controller |
| mem_regspace | output | 1 | 1 = register-space access |
| mem_wdata | output | 64 | Wide write data, big-endian |
| mem_side | output | 4 | Side-bus write bits, one per lane |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Returned doubleword |
| mem_rside | input | 4 | Returned side bits |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Processor accepts response |
| rsp_rdata | output | 32 | Read result |
| rsp_err | output | 1 | Read refused (repeat mode) |

## Verification
The assertions assume that `mem_rvalid` pulses only while a memory read is outstanding, and that the memory controller and the processor follow the handshake. A holder of valid never withdraws it. The stimulus respects both. Each scenario drives one request, then drops `req_valid` once the request is taken. It pulses `mem_rvalid` only after the read request has been accepted. It holds `mem_ready` and `rsp_ready` low for a cycle before raising them, so that the stability rule is exercised. Control writes are made only while the block is idle.

// File: rtl/lm_pkg.sv
package lm_pkg;
  typedef enum logic [1:0] {
    MODE_NORM  = 2'd0,
    MODE_UPPER = 2'd1,
    MODE_SIDE  = 2'd2,
    MODE_REP   = 2'd3
  } lane_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } lm_state_e;
endpackage

// File: rtl/lm_ctrl_reg.sv
module lm_ctrl_reg
  import lm_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          set_upper,
  input  logic          set_side,
  input  logic          set_rep,
  input  logic [CW-1:0] rep_cnt_in,
  output lane_mode_e    mode,
  output logic [CW-1:0] rep_cnt
);
  lane_mode_e mode_nxt;

  always_comb begin
    if (set_rep)        mode_nxt = MODE_REP;
    else if (set_side)  mode_nxt = MODE_SIDE;
    else if (set_upper) mode_nxt = MODE_UPPER;
    else                mode_nxt = MODE_NORM;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MODE_NORM;
      rep_cnt <= '0;
    end else if (we) begin
      mode    <= mode_nxt;
      rep_cnt <= rep_cnt_in;
    end
  end

  AST_REP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    we && set_rep |=> mode == MODE_REP); // R9
  AST_SIDE_OVER_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    we && set_side && !set_rep |=> mode == MODE_SIDE); // R9
endmodule

// File: rtl/lm_lane_pack.sv
module lm_lane_pack
  import lm_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 7,
  parameter int SZW = 3,
  localparam int LANES = DW / 8
) (
  input  lane_mode_e         mode,
  input  logic               is_mem,
  input  logic               a2,
  input  logic [DW-1:0]      word,
  input  logic [SZW-1:0]     size,
  input  logic [CW-1:0]      rep_cnt,
  output logic [2*DW-1:0]    bus,
  output logic [LANES-1:0]   side,
  output logic [CW-1:0]      cnt
);
  logic [LANES-1:0] side_bits;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign side_bits[i] = word[i];
  end

  always_comb begin
    bus  = '0;
    side = '0;
    cnt  = CW'(size);
    if (!is_mem) begin
      bus[DW-1:0] = word;
    end else begin
      unique case (mode)
        MODE_NORM: begin
          if (a2) bus[DW-1:0]    = word;
          else    bus[2*DW-1:DW] = word;
        end
        MODE_UPPER: bus[2*DW-1:DW] = word;
        MODE_SIDE:  side = side_bits;
        MODE_REP: begin
          bus = {word, word};
          cnt = rep_cnt;
        end
        default: bus = '0;
      endcase
    end
  end
endmodule

// File: rtl/lm_lane_pick.sv
module lm_lane_pick
  import lm_pkg::*;
#(
  parameter int DW = 32,
  localparam int LANES = DW / 8
) (
  input  lane_mode_e        mode,
  input  logic              is_mem,
  input  logic              a2,
  input  logic [2*DW-1:0]   bus,
  input  logic [LANES-1:0]  side,
  output logic [DW-1:0]     word
);
  always_comb begin
    if (!is_mem) begin
      word = bus[DW-1:0];
    end else begin
      unique case (mode)
        MODE_UPPER: word = bus[2*DW-1:DW];
        MODE_SIDE:  word = DW'(side);
        default:    word = a2 ? bus[DW-1:0] : bus[2*DW-1:DW];
      endcase
    end
  end
endmodule

// File: rtl/lane_mapper.sv
module lane_mapper
  import lm_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          CW        = 7,
  parameter int          SZW       = 3,
  parameter logic [31:0] MEM_LIMIT = 32'h0400_0000,
  localparam int         LANES     = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_upper,
  input  logic             cfg_side,
  input  logic             cfg_rep,
  input  logic [CW-1:0]    cfg_rep_cnt,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [SZW-1:0]   req_size,
  input  logic [DW-1:0]    req_wdata,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_write,
  output logic [AW-1:0]    mem_addr,
  output logic [CW-1:0]    mem_count,
  output logic             mem_regspace,
  output logic [2*DW-1:0]  mem_wdata,
  output logic [LANES-1:0] mem_side,
  input  logic             mem_rvalid,
  input  logic [2*DW-1:0]  mem_rdata,
  input  logic [LANES-1:0] mem_rside,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_err
);
  lane_mode_e       live_mode, cur_mode;
  logic [CW-1:0]    rep_cnt;
  lm_state_e        state;
  logic             cur_mem, cur_a2;
  logic             req_is_mem;
  logic [2*DW-1:0]  pk_bus;
  logic [LANES-1:0] pk_side;
  logic [CW-1:0]    pk_cnt;
  logic [DW-1:0]    pick_word;

  lm_ctrl_reg #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .set_upper(cfg_upper), .set_side(cfg_side), .set_rep(cfg_rep),
    .rep_cnt_in(cfg_rep_cnt), .mode(live_mode), .rep_cnt(rep_cnt)
  );

  assign req_is_mem = (32'(req_addr) < MEM_LIMIT);

  lm_lane_pack #(.DW(DW), .CW(CW), .SZW(SZW)) u_pack (
    .mode(live_mode), .is_mem(req_is_mem), .a2(req_addr[2]),
    .word(req_wdata), .size(req_size), .rep_cnt(rep_cnt),
    .bus(pk_bus), .side(pk_side), .cnt(pk_cnt)
  );

  lm_lane_pick #(.DW(DW)) u_pick (
    .mode(cur_mode), .is_mem(cur_mem), .a2(cur_a2),
    .bus(mem_rdata), .side(mem_rside), .word(pick_word)
  );

  assign req_ready    = (state == ST_IDLE);
  assign mem_valid    = (state == ST_ISSUE);
  assign rsp_valid    = (state == ST_RESP);
  assign mem_regspace = !cur_mem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_mode  <= MODE_NORM;
      cur_mem   <= 1'b1;
      cur_a2    <= 1'b0;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_count <= '0;
      mem_wdata <= '0;
      mem_side  <= '0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          cur_mode  <= live_mode;
          cur_mem   <= req_is_mem;
          cur_a2    <= req_addr[2];
          mem_write <= req_write;
          mem_addr  <= req_addr;
          mem_count <= pk_cnt;
          mem_wdata <= req_write ? pk_bus : '0;
          mem_side  <= req_write ? pk_side : '0;
          if (!req_write && req_is_mem && live_mode == MODE_REP) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b1;
            state     <= ST_RESP;
          end else begin
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_ready) state <= mem_write ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (mem_rvalid) begin
          rsp_rdata <= pick_word;
          rsp_err   <= 1'b0;
          state     <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_wdata) && $stable(mem_count) && $stable(mem_side)); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)); // R10
  AST_NORM_SIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && cur_mode == MODE_NORM |-> mem_side == '0); // R2
  AST_REP_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && cur_mem && cur_mode == MODE_REP |-> mem_wdata[2*DW-1:DW] == mem_wdata[DW-1:0]); // R5
  AST_REP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && cur_mem && cur_mode == MODE_REP |-> mem_write); // R6
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == '0); // R6
  AST_REG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !cur_mem |-> mem_wdata[2*DW-1:DW] == '0 && mem_side == '0); // R8
endmodule

// File: tb/lane_mapper_tb.sv
`timescale 1ns/1ps
module lane_mapper_tb_top;
  import lm_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_upper = 0, cfg_side = 0, cfg_rep = 0;
  logic [6:0] cfg_rep_cnt = '0;
  logic req_valid = 0, req_write = 0;
  logic req_ready;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [2:0] req_size = 3'd4;
  logic mem_valid, mem_write, mem_regspace;
  logic mem_ready = 0;
  logic [31:0] mem_addr;
  logic [6:0] mem_count;
  logic [63:0] mem_wdata;
  logic [3:0] mem_side;
  logic mem_rvalid = 0;
  logic [63:0] mem_rdata = '0;
  logic [3:0] mem_rside = '0;
  logic rsp_valid, rsp_err;
  logic rsp_ready = 0;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lane_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_upper(cfg_upper),
    .cfg_side(cfg_side), .cfg_rep(cfg_rep), .cfg_rep_cnt(cfg_rep_cnt),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_count(mem_count), .mem_regspace(mem_regspace),
    .mem_wdata(mem_wdata), .mem_side(mem_side), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_rside(mem_rside), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic u, input logic s, input logic r, input logic [6:0] c);
    @(negedge clk);
    cfg_we = 1; cfg_upper = u; cfg_side = s; cfg_rep = r; cfg_rep_cnt = c;
    @(negedge clk);
    cfg_we = 0; cfg_upper = 0; cfg_side = 0; cfg_rep = 0;
  endtask

  task automatic send(input logic wr, input logic [31:0] a, input logic [31:0] w, input logic [2:0] sz);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = w; req_size = sz;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_write(input string tag, input logic [31:0] a, input logic [31:0] w,
                          input logic [2:0] sz, input logic [63:0] ebus, input logic [3:0] eside,
                          input logic [6:0] ecnt, input logic ereg);
    send(1'b1, a, w, sz);
    chk({tag, " mem_valid"}, 64'(mem_valid), 64'd1);
    chk({tag, " wdata"}, mem_wdata, ebus);
    chk({tag, " side"}, 64'(mem_side), 64'(eside));
    chk({tag, " count"}, 64'(mem_count), 64'(ecnt));
    chk({tag, " regspace"}, 64'(mem_regspace), 64'(ereg));
    chk({tag, " R10 busy"}, 64'(req_ready), 64'd0);
    @(negedge clk);
    chk({tag, " R10 hold"}, {mem_wdata[62:0], mem_valid}, {ebus[62:0], 1'b1});
    mem_ready = 1;
    @(negedge clk);
    mem_ready = 0;
    chk({tag, " R10 idle"}, {62'd0, mem_valid, req_ready}, 64'd1);
  endtask

  task automatic do_read(input string tag, input logic [31:0] a, input logic expect_mem,
                         input logic [63:0] rbus, input logic [3:0] rside,
                         input logic [31:0] edata, input logic eerr);
    send(1'b0, a, 32'h0, 3'd4);
    if (expect_mem) begin
      chk({tag, " read issued"}, {62'd0, mem_valid, mem_write}, 64'd2);
      mem_ready = 1;
      @(negedge clk);
      mem_ready = 0;
      mem_rvalid = 1; mem_rdata = rbus; mem_rside = rside;
      @(negedge clk);
      mem_rvalid = 0; mem_rdata = '0; mem_rside = '0;
    end else begin
      chk({tag, " no mem req"}, 64'(mem_valid), 64'd0);
    end
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " rdata"}, 64'(rsp_rdata), 64'(edata));
    chk({tag, " err"}, 64'(rsp_err), 64'(eerr));
    @(negedge clk);
    chk({tag, " R10 rsp hold"}, {31'd0, rsp_valid, rsp_rdata}, {31'd0, 1'b1, edata});
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk({tag, " R10 rsp done"}, {62'd0, rsp_valid, req_ready}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 mem_valid", 64'(mem_valid), 64'd0);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    do_write("R1 default normal", 32'h100, 32'hCAFE_0001, 3'd4,
             64'hCAFE_0001_0000_0000, 4'h0, 7'd4, 1'b0);
  endtask

  task automatic t_normal;
    do_write("R2 a2=0", 32'h200, 32'h1234_5678, 3'd4, 64'h1234_5678_0000_0000, 4'h0, 7'd4, 1'b0);
    do_write("R2 a2=1", 32'h204, 32'h89AB_CDEF, 3'd2, 64'h0000_0000_89AB_CDEF, 4'h0, 7'd2, 1'b0);
    do_read("R7 a2=0", 32'h300, 1'b1, 64'h1111_2222_3333_4444, 4'h5, 32'h1111_2222, 1'b0);
    do_read("R7 a2=1", 32'h304, 1'b1, 64'h1111_2222_3333_4444, 4'h5, 32'h3333_4444, 1'b0);
  endtask

  task automatic t_upper;
    set_cfg(1, 0, 0, 7'd0);
    do_write("R3 a2=1", 32'h404, 32'hA5A5_0F0F, 3'd4, 64'hA5A5_0F0F_0000_0000, 4'h0, 7'd4, 1'b0);
    do_read("R3 read a2=1", 32'h404, 1'b1, 64'hDEAD_BEEF_0BAD_F00D, 4'h0, 32'hDEAD_BEEF, 1'b0);
  endtask

  task automatic t_side;
    set_cfg(0, 1, 0, 7'd0);
    do_write("R4 side", 32'h500, 32'hFFFF_FFF9, 3'd4, 64'h0, 4'h9, 7'd4, 1'b0);
    do_read("R4 side read", 32'h504, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'hA, 32'h0000_000A, 1'b0);
  endtask

  task automatic t_repeat;
    set_cfg(0, 0, 1, 7'd15);
    do_write("R5 repeat", 32'h604, 32'h0102_0304, 3'd4, 64'h0102_0304_0102_0304, 4'h0, 7'd15, 1'b0);
    do_read("R6 repeat read", 32'h600, 1'b0, 64'h0, 4'h0, 32'h0, 1'b1);
  endtask

  task automatic t_regspace;
    do_write("R8 reg write", 32'h0400_0010, 32'h7777_8888, 3'd4, 64'h0000_0000_7777_8888, 4'h0, 7'd4, 1'b1);
    do_read("R8 reg read", 32'h0400_0010, 1'b1, 64'h9999_AAAA_BBBB_CCCC, 4'h0, 32'hBBBB_CCCC, 1'b0);
  endtask

  task automatic t_priority;
    set_cfg(1, 1, 1, 7'd7);
    do_write("R9 rep wins", 32'h700, 32'h5555_AAAA, 3'd4, 64'h5555_AAAA_5555_AAAA, 4'h0, 7'd7, 1'b0);
    set_cfg(1, 1, 0, 7'd0);
    do_write("R9 side wins", 32'h700, 32'h0000_0006, 3'd4, 64'h0, 4'h6, 7'd4, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_normal;
    t_regspace;
    t_upper;
    t_side;
    t_repeat;
    t_regspace;
    t_priority;
    set_cfg(0, 0, 0, 7'd0);
    do_write("R2 back to normal", 32'h800, 32'h0000_00FF, 3'd1, 64'h0000_00FF_0000_0000, 4'h0, 7'd1, 1'b0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule